// File: doc/BRIEF.md
# I2C Client Address Match Unit

This block is the address-recognition stage of an I2C client. A receive shift register hands it complete bytes, one per `rx_valid` pulse, and raises `rx_first` on the first byte after a START or repeated START. The block compares the address bytes against four programmable 8-bit slot registers. It raises a one-cycle match pulse that carries the matched entry number and the read/write direction.

A 2-bit mode selects how the four slot registers are read. The choices are four plain 7-bit addresses, two 7-bit address/mask pairs, two 10-bit addresses, or one 10-bit address with a 10-bit mask. In 10-bit modes the register holding the upper part contains a whole high byte: the conventional `11110` prefix sits in bits 7:3, address bits 9:8 sit in bits 2:1, and bit 0 is the direction position. Hardware does not enforce the prefix. The register is compared exactly as programmed.

Matched address bytes are captured in one of two places, chosen by a disable control:
- **Disable low:** two dedicated address-capture registers.
- **Disable high:** the shared single-entry receive buffer. A second matched byte that arrives while the buffer is still full is held back until software reads the buffer.

Top module: `i2c_addr_match`

## Requirements
- R1: After a synchronous reset, `match_pulse`, `match_slot`, `match_rw`, both capture registers, `rxbuf_data` and `rxbuf_full` are all zero.
- R2: In mode 0 (`mode`=2'b00), a byte flagged `rx_first` matches slot k when its bits 7:1 equal bits 7:1 of `addr_slotk`; bit 0 is never compared. The lowest matching k wins. `match_pulse` rises on the clock edge that accepts the byte, and `match_slot`=k.
- R3: In mode 1 (`mode`=2'b01), entry 0 compares against `addr_slot0` and entry 1 compares against `addr_slot2`. The masks are `addr_slot1` and `addr_slot3` respectively, and a mask bit of 1 excludes that bit from the comparison. A match reports `match_slot` 0 or 1.
- R4: In mode 2 (`mode`=2'b10), the first byte is compared in bits 7:1 against `addr_slot1` (entry 0) and `addr_slot3` (entry 1). The next byte is compared in all 8 bits against `addr_slot0` or `addr_slot2` of a surviving entry. The match pulse, with the lowest surviving entry number, comes on the edge that accepts the second byte.
- R5: In mode 3 (`mode`=2'b11), the address is {`addr_slot1`, `addr_slot0`}. `addr_slot3` masks the high byte and `addr_slot2` masks the low byte. `match_slot` is always 0. No fixed prefix is required: the programmed high byte alone decides.
- R6: A mismatch on any address byte leaves the block ignoring bytes until the next `rx_first` byte. A byte flagged `rx_first` always restarts recognition, even halfway through a 10-bit address.
- R7: With `adb_dis`=0, a 7-bit match writes the address byte to `abuf0` and leaves `abuf1` unchanged. A 10-bit match writes the low byte to `abuf0` and the high byte to `abuf1`, both on the matching edge.
- R8: With `adb_dis`=1, `abuf0` and `abuf1` never change, and matched bytes load `rxbuf_data` and set `rxbuf_full`. In 10-bit modes the high byte is loaded when it matches, and the low byte is loaded after it, once the full address matches.
- R9: A matched byte that arrives while `rxbuf_full`=1 with no `rxbuf_read` is held back. A later `rxbuf_read` moves the held byte into `rxbuf_data` and keeps `rxbuf_full`=1. A read with nothing held clears `rxbuf_full`. A read in the same cycle as a new matched byte loads that byte.
- R10: `match_rw` equals bit 0 of the first address byte. `match_pulse` lasts one cycle per recognised address and never follows a cycle without `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Addressing mode select |
| adb_dis | input | 1 | 1 routes matched bytes to the receive buffer instead of the capture registers |
| addr_slot0 | input | 8 | Slot register 0 |
| addr_slot1 | input | 8 | Slot register 1 |
| addr_slot2 | input | 8 | Slot register 2 |
| addr_slot3 | input | 8 | Slot register 3 |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_first | input | 1 | The present byte is the first after START or repeated START |
| rx_byte | input | 8 | Received byte |
| rxbuf_read | input | 1 | Software read strobe for the receive buffer |
| match_pulse | output | 1 | One-cycle address match indication |
| match_slot | output | 2 | Matched entry number |
| match_rw | output | 1 | Direction bit of the matched address |
| abuf0 | output | 8 | Address capture register, low / 7-bit byte |
| abuf1 | output | 8 | Address capture register, 10-bit high byte |
| rxbuf_data | output | 8 | Receive buffer contents |
| rxbuf_full | output | 1 | Receive buffer holds an unread byte |

## Verification
The block has one configuration: an 8-bit byte and four slot registers, both fixed in the package. The bench builds it as is and reaches every mode by driving the mode and slot ports at run time. That gives it masked and unmasked compares, ties between duplicated slots, a 10-bit address that fails on its second byte, and a restart in the middle of a 10-bit address. With the buffer-disable control high, the bench drives the stall path: a held low byte, a read that releases it, and a read that coincides with a new matched byte.

// File: rtl/amatch_pkg.sv
package amatch_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 4;
    localparam int NUM_PAIRS = NUM_SLOTS / 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        AM_SEVEN      = 2'b00,
        AM_SEVEN_MASK = 2'b01,
        AM_TEN        = 2'b10,
        AM_TEN_MASK   = 2'b11
    } amode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_LOW  = 1'b1
    } seq_e;

    // capture events raised in the cycle a byte is accepted
    typedef struct packed {
        logic seven;   // 7-bit address recognised
        logic high;    // 10-bit high byte survived
        logic low;     // 10-bit address complete
    } cap_ev_t;

    localparam byte_t RW_ONLY = byte_t'(1);

    function automatic logic bits_agree(input byte_t a, input byte_t b, input byte_t ign);
        return ((a ^ b) & ~ign) == '0;
    endfunction

    function automatic logic [SLOT_W-1:0] first_hit(input logic [NUM_SLOTS-1:0] v);
        logic [SLOT_W-1:0] idx;
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (v[i]) idx = SLOT_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/amatch_cmp.sv
module amatch_cmp
    import amatch_pkg::*;
(
    input  amode_e                      mode,
    input  byte_t [NUM_SLOTS-1:0]       regs,
    input  byte_t                       rx_byte,
    output logic  [NUM_SLOTS-1:0]       hit7,
    output logic  [NUM_PAIRS-1:0]       hi_hit,
    output logic  [NUM_PAIRS-1:0]       lo_hit
);

    logic [NUM_SLOTS-1:0] plain;
    logic [NUM_PAIRS-1:0] masked;
    logic [NUM_PAIRS-1:0] hi_plain;
    logic [NUM_PAIRS-1:0] lo_plain;
    logic                 hi_msk;
    logic                 lo_msk;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign plain[k] = bits_agree(rx_byte, regs[k], RW_ONLY);
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign masked[p]   = bits_agree(rx_byte, regs[2*p], regs[2*p+1] | RW_ONLY);
        assign hi_plain[p] = bits_agree(rx_byte, regs[2*p+1], RW_ONLY);
        assign lo_plain[p] = bits_agree(rx_byte, regs[2*p], '0);
    end

    // single masked 10-bit address: value in slots 1:0, mask in slots 3:2
    assign hi_msk = bits_agree(rx_byte, regs[1], regs[3] | RW_ONLY);
    assign lo_msk = bits_agree(rx_byte, regs[0], regs[2]);

    always_comb begin
        hit7   = '0;
        hi_hit = '0;
        lo_hit = '0;
        case (mode)
            AM_SEVEN:      hit7 = plain;
            AM_SEVEN_MASK: hit7 = NUM_SLOTS'(masked);
            AM_TEN: begin
                hi_hit = hi_plain;
                lo_hit = lo_plain;
            end
            AM_TEN_MASK: begin
                hi_hit[0] = hi_msk;
                lo_hit[0] = lo_msk;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/amatch_seq.sv
module amatch_seq
    import amatch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  amode_e                mode,
    input  logic                  rx_valid,
    input  logic                  rx_first,
    input  byte_t                 rx_byte,
    input  logic [NUM_SLOTS-1:0]  hit7,
    input  logic [NUM_PAIRS-1:0]  hi_hit,
    input  logic [NUM_PAIRS-1:0]  lo_hit,
    output logic                  match_pulse,
    output logic [SLOT_W-1:0]     match_slot,
    output logic                  match_rw,
    output cap_ev_t               ev,
    output byte_t                 hi_byte
);

    seq_e                 state_q;
    logic [NUM_PAIRS-1:0] cand_q;
    logic [NUM_PAIRS-1:0] pair_win;
    byte_t                hi_q;
    logic                 rw_q;
    logic                 ten;

    assign ten      = mode[1];
    assign pair_win = cand_q & lo_hit;
    assign hi_byte  = hi_q;

    assign ev.seven = rx_valid & rx_first & ~ten & (|hit7);
    assign ev.high  = rx_valid & rx_first & ten & (|hi_hit);
    assign ev.low   = rx_valid & ~rx_first & (state_q == SEQ_LOW) & (|pair_win);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            cand_q      <= '0;
            hi_q        <= '0;
            rw_q        <= 1'b0;
            match_pulse <= 1'b0;
            match_slot  <= '0;
            match_rw    <= 1'b0;
        end else begin
            match_pulse <= 1'b0;
            if (rx_valid && rx_first) begin
                if (!ten) begin
                    state_q <= SEQ_IDLE;
                    if (|hit7) begin
                        match_pulse <= 1'b1;
                        match_slot  <= first_hit(hit7);
                        match_rw    <= rx_byte[0];
                    end
                end else begin
                    cand_q  <= hi_hit;
                    hi_q    <= rx_byte;
                    rw_q    <= rx_byte[0];
                    state_q <= (|hi_hit) ? SEQ_LOW : SEQ_IDLE;
                end
            end else if (rx_valid && state_q == SEQ_LOW) begin
                state_q <= SEQ_IDLE;
                if (|pair_win) begin
                    match_pulse <= 1'b1;
                    match_slot  <= first_hit(NUM_SLOTS'(pair_win));
                    match_rw    <= rw_q;
                end
            end
        end
    end

    // R10: a match only ever follows an accepted byte
    a_r10_pulse_after_byte: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> $past(rx_valid));

    // R5: the masked 10-bit mode has a single entry
    a_r5_single_entry: assert property (@(posedge clk) disable iff (rst)
        (match_pulse && $past(mode) == AM_TEN_MASK) |-> (match_slot == '0));

endmodule

// File: rtl/amatch_capture.sv
module amatch_capture
    import amatch_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adb_dis,
    input  cap_ev_t ev,
    input  byte_t   rx_byte,
    input  byte_t   hi_byte,
    input  logic    rd,
    output byte_t   abuf0,
    output byte_t   abuf1,
    output byte_t   rxbuf_data,
    output logic    rxbuf_full
);

    logic  wr;
    logic  room;
    logic  pend_v;
    byte_t pend_q;

    assign wr   = adb_dis & (ev.seven | ev.high | ev.low);
    assign room = ~rxbuf_full | rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            abuf0 <= '0;
            abuf1 <= '0;
        end else if (!adb_dis) begin
            if (ev.seven || ev.low) abuf0 <= rx_byte;
            if (ev.low)             abuf1 <= hi_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxbuf_data <= '0;
            rxbuf_full <= 1'b0;
            pend_v     <= 1'b0;
            pend_q     <= '0;
        end else begin
            if (rd) rxbuf_full <= 1'b0;
            if (pend_v && room) begin
                rxbuf_data <= pend_q;
                rxbuf_full <= 1'b1;
                pend_v     <= wr;
                if (wr) pend_q <= rx_byte;
            end else if (wr && room) begin
                rxbuf_data <= rx_byte;
                rxbuf_full <= 1'b1;
            end else if (wr) begin
                pend_q <= rx_byte;
                pend_v <= 1'b1;
            end
        end
    end

    // R9: the buffer only empties through a software read
    a_r9_empty_on_read: assert property (@(posedge clk) disable iff (rst)
        $fell(rxbuf_full) |-> $past(rd));

    // R8: capture registers are frozen while routing to the receive buffer
    a_r8_abuf_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(adb_dis) |-> ($stable(abuf0) && $stable(abuf1)));

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import amatch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode,
    input  logic        adb_dis,
    input  logic [7:0]  addr_slot0,
    input  logic [7:0]  addr_slot1,
    input  logic [7:0]  addr_slot2,
    input  logic [7:0]  addr_slot3,
    input  logic        rx_valid,
    input  logic        rx_first,
    input  logic [7:0]  rx_byte,
    input  logic        rxbuf_read,
    output logic        match_pulse,
    output logic [1:0]  match_slot,
    output logic        match_rw,
    output logic [7:0]  abuf0,
    output logic [7:0]  abuf1,
    output logic [7:0]  rxbuf_data,
    output logic        rxbuf_full
);

    amode_e                mode_e;
    byte_t [NUM_SLOTS-1:0] regs;
    logic  [NUM_SLOTS-1:0] hit7;
    logic  [NUM_PAIRS-1:0] hi_hit;
    logic  [NUM_PAIRS-1:0] lo_hit;
    cap_ev_t               ev;
    byte_t                 hi_byte;

    assign mode_e = amode_e'(mode);
    assign regs   = {addr_slot3, addr_slot2, addr_slot1, addr_slot0};

    amatch_cmp u_cmp (
        .mode    (mode_e),
        .regs    (regs),
        .rx_byte (rx_byte),
        .hit7    (hit7),
        .hi_hit  (hi_hit),
        .lo_hit  (lo_hit)
    );

    amatch_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode_e),
        .rx_valid    (rx_valid),
        .rx_first    (rx_first),
        .rx_byte     (rx_byte),
        .hit7        (hit7),
        .hi_hit      (hi_hit),
        .lo_hit      (lo_hit),
        .match_pulse (match_pulse),
        .match_slot  (match_slot),
        .match_rw    (match_rw),
        .ev          (ev),
        .hi_byte     (hi_byte)
    );

    amatch_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .adb_dis    (adb_dis),
        .ev         (ev),
        .rx_byte    (rx_byte),
        .hi_byte    (hi_byte),
        .rd         (rxbuf_read),
        .abuf0      (abuf0),
        .abuf1      (abuf1),
        .rxbuf_data (rxbuf_data),
        .rxbuf_full (rxbuf_full)
    );

    // R7: the high capture register is untouched in 7-bit modes
    a_r7_abuf1_idle_7bit: assert property (@(posedge clk) disable iff (rst)
        !$past(mode[1]) |-> $stable(abuf1));

endmodule

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic       adb_dis;
    logic [7:0] ar [4];
    logic       rx_valid, rx_first, rd;
    logic [7:0] rx_byte;
    logic       match_pulse, match_rw, rxbuf_full;
    logic [1:0] match_slot;
    logic [7:0] abuf0, abuf1, rxbuf_data;

    always #5 clk = ~clk;

    i2c_addr_match uut (
        .clk(clk), .rst(rst), .mode(mode), .adb_dis(adb_dis),
        .addr_slot0(ar[0]), .addr_slot1(ar[1]), .addr_slot2(ar[2]), .addr_slot3(ar[3]),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_byte(rx_byte), .rxbuf_read(rd),
        .match_pulse(match_pulse), .match_slot(match_slot), .match_rw(match_rw),
        .abuf0(abuf0), .abuf1(abuf1), .rxbuf_data(rxbuf_data), .rxbuf_full(rxbuf_full)
    );

    // reference model state
    logic       e_pulse, e_rw, e_full;
    logic [1:0] e_slot;
    logic [7:0] e_ab0, e_ab1, e_rxd;
    bit         m_low, m_rw;
    bit   [1:0] m_cand;
    logic [7:0] m_hi;
    bit         m_pend_v;
    logic [7:0] m_pend;

    int    vectors = 0;
    int    miscompares = 0;
    string req = "R1";
    bit    finished = 0;

    function automatic bit same(input logic [7:0] a, input logic [7:0] b, input logic [7:0] ign);
        return ((a ^ b) & ~ign) == 8'h00;
    endfunction

    task automatic model_reset();
        e_pulse = 0; e_rw = 0; e_full = 0; e_slot = 0;
        e_ab0 = 0; e_ab1 = 0; e_rxd = 0;
        m_low = 0; m_rw = 0; m_cand = 0; m_hi = 0; m_pend_v = 0; m_pend = 0;
    endtask

    task automatic model_tick();
        bit       wr;
        bit       room;
        int       win;
        bit [1:0] cand;
        bit [1:0] lo;
        wr = 0; win = -1;
        e_pulse = 0;
        if (rx_valid && rx_first) begin
            m_low = 0;
            if (mode < 2) begin
                if (mode == 0) begin
                    for (int k = 0; k < 4; k++)
                        if (win < 0 && same(rx_byte, ar[k], 8'h01)) win = k;
                end else begin
                    for (int k = 0; k < 2; k++)
                        if (win < 0 && same(rx_byte, ar[2*k], ar[2*k+1] | 8'h01)) win = k;
                end
                if (win >= 0) begin
                    e_pulse = 1; e_slot = win[1:0]; e_rw = rx_byte[0];
                    if (adb_dis) wr = 1; else e_ab0 = rx_byte;
                end
            end else begin
                if (mode == 2) cand = {same(rx_byte, ar[3], 8'h01), same(rx_byte, ar[1], 8'h01)};
                else           cand = {1'b0, same(rx_byte, ar[1], ar[3] | 8'h01)};
                if (cand != 0) begin
                    m_low = 1; m_cand = cand; m_hi = rx_byte; m_rw = rx_byte[0];
                    if (adb_dis) wr = 1;
                end
            end
        end else if (rx_valid && m_low) begin
            m_low = 0;
            if (mode == 2) lo = {same(rx_byte, ar[2], 8'h00), same(rx_byte, ar[0], 8'h00)};
            else           lo = {1'b0, same(rx_byte, ar[0], ar[2])};
            lo &= m_cand;
            if (lo != 0) begin
                e_pulse = 1; e_slot = lo[0] ? 2'd0 : 2'd1; e_rw = m_rw;
                if (adb_dis) wr = 1;
                else begin e_ab0 = rx_byte; e_ab1 = m_hi; end
            end
        end
        room = !e_full || rd;
        if (rd) e_full = 0;
        if (m_pend_v && room) begin
            e_rxd = m_pend; e_full = 1; m_pend_v = wr;
            if (wr) m_pend = rx_byte;
        end else if (wr && room) begin
            e_rxd = rx_byte; e_full = 1;
        end else if (wr) begin
            m_pend = rx_byte; m_pend_v = 1;
        end
    endtask

    task automatic compare();
        vectors++;
        if (match_pulse !== e_pulse || match_slot !== e_slot || match_rw !== e_rw ||
            abuf0 !== e_ab0 || abuf1 !== e_ab1 || rxbuf_data !== e_rxd || rxbuf_full !== e_full) begin
            miscompares++;
            $display("FAIL %s: pulse/slot/rw/ab0/ab1/rxd/full got %b/%0d/%b/%h/%h/%h/%b expected %b/%0d/%b/%h/%h/%h/%b",
                     req, match_pulse, match_slot, match_rw, abuf0, abuf1, rxbuf_data, rxbuf_full,
                     e_pulse, e_slot, e_rw, e_ab0, e_ab1, e_rxd, e_full);
        end
    endtask

    task automatic step(input bit v, input bit f, input logic [7:0] b, input bit r);
        rx_valid = v; rx_first = f; rx_byte = b; rd = r;
        model_tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic cfg(input logic [1:0] m, input bit d, input logic [7:0] a0, input logic [7:0] a1,
                       input logic [7:0] a2, input logic [7:0] a3);
        mode = m; adb_dis = d; ar[0] = a0; ar[1] = a1; ar[2] = a2; ar[3] = a3;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got no completion, expected the run to finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; rx_valid = 0; rx_first = 0; rx_byte = 0; rd = 0;
        cfg(2'd0, 1'b0, 8'h20, 8'h22, 8'h40, 8'h20);
        repeat (3) @(negedge clk);
        model_reset();
        rst = 0;
        req = "R1";
        compare();                       // R1 reset state

        // R2: four plain 7-bit slots, slot 3 duplicates slot 0
        req = "R2";
        step(1, 1, 8'h23, 0);            // slot 1, rw 1
        step(0, 0, 8'h00, 0);            // pulse drops after one cycle
        step(1, 1, 8'h41, 0);            // slot 2
        step(1, 1, 8'h20, 0);            // slot 0 beats duplicate slot 3
        step(1, 1, 8'h50, 0);            // no match
        step(1, 0, 8'h22, 0);            // not flagged first: ignored
        req = "R10";
        step(1, 1, 8'h22, 0);            // R10 rw 0
        step(0, 0, 8'h00, 0);

        // R3: masked 7-bit pairs
        req = "R3";
        cfg(2'd1, 1'b0, 8'hA0, 8'h0E, 8'h60, 8'h00);
        step(1, 1, 8'hAE, 0);            // entry 0 via mask
        step(1, 1, 8'hB0, 0);            // miss
        step(1, 1, 8'h61, 0);            // entry 1, rw 1
        step(0, 0, 8'h00, 0);

        // R4 / R7: two 10-bit addresses captured into abuf0/abuf1
        req = "R4";
        cfg(2'd2, 1'b0, 8'h34, 8'hF2, 8'h56, 8'hF6);
        step(1, 1, 8'hF3, 0);
        step(1, 0, 8'h34, 0);            // entry 0, rw 1, R7 capture
        step(1, 1, 8'hF6, 0);
        step(0, 0, 8'h00, 0);            // gap between bytes
        step(1, 0, 8'h56, 0);            // entry 1, rw 0

        // R6: mismatch on low byte, stale bytes, restart midway
        req = "R6";
        step(1, 1, 8'hF2, 0);
        step(1, 0, 8'h56, 0);            // low byte of other entry: miss
        step(1, 0, 8'h34, 0);            // ignored until next first byte
        step(1, 1, 8'hF0, 0);            // high byte miss
        step(1, 0, 8'h34, 0);            // ignored
        step(1, 1, 8'hF3, 0);
        step(1, 1, 8'hF6, 0);            // restart as high byte
        step(1, 0, 8'h56, 0);            // entry 1

        // R5: masked 10-bit, prefix not required
        req = "R5";
        cfg(2'd3, 1'b0, 8'h12, 8'h04, 8'h0F, 8'h00);
        step(1, 1, 8'h05, 0);
        step(1, 0, 8'h1A, 0);            // match, rw 1
        step(1, 1, 8'hF4, 0);            // prefix present but not programmed: miss
        step(1, 0, 8'h12, 0);
        ar[3] = 8'hF8;                   // mask out the prefix bits
        step(1, 1, 8'hF4, 0);
        step(1, 0, 8'h19, 0);            // match, rw 0

        // R7: 7-bit capture leaves abuf1 alone
        req = "R7";
        cfg(2'd0, 1'b0, 8'h20, 8'h22, 8'h40, 8'h20);
        step(1, 1, 8'h41, 0);
        step(0, 0, 8'h00, 0);

        // R8: receive-buffer routing, capture registers frozen
        req = "R8";
        cfg(2'd0, 1'b1, 8'h20, 8'h22, 8'h40, 8'h20);
        step(1, 1, 8'h23, 0);
        step(1, 1, 8'h41, 1);            // R9 read with simultaneous write
        step(1, 1, 8'h50, 0);            // miss: buffer unchanged
        step(0, 0, 8'h00, 1);            // read empties

        // R9: stall of the low byte behind an unread high byte
        req = "R9";
        cfg(2'd2, 1'b1, 8'h34, 8'hF2, 8'h56, 8'hF6);
        step(1, 1, 8'hF3, 0);            // high byte into buffer
        step(1, 0, 8'h34, 0);            // match, low byte held
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 1);            // held byte released
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 1);            // empties
        step(0, 0, 8'h00, 1);            // read on empty buffer
        step(0, 0, 8'h00, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule